// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial line into parallel characters. A clock enable, `tick16`, pulses sixteen times per bit period, and all bit timing advances only on those pulses. While the line is idle it sits high. A falling level marks a possible start bit. The receiver confirms the start at its centre, then samples each later bit at its own centre. It gathers 5 to 8 data bits, least significant bit first, followed by an optional parity bit. It then samples the first stop bit.

At the first stop bit's centre the character is written right-justified into the receive buffer. The data-ready flag is set at the same moment, together with the parity, framing and overrun results. The host acknowledges a character by driving `dr_clr_n` low. The character format comes from a small control word, captured while `cfg_load` is high. The transmitter uses the same control word.

Top module: `serial_rx_flags`

## Requirements
- R1: After synchronous reset, `rx_data` is 0 and `data_rdy`, `err_parity`, `err_frame` and `err_overrun` are all low.
- R2: A start is accepted only if the line is still low at the start bit's centre, 8 ticks after the falling level is seen. A low pulse shorter than half a bit returns the receiver to idle and produces no character.
- R3: `cfg_len` selects the data length: 00 = 5 bits, 01 = 6, 10 = 7, 11 = 8. Data arrives least significant bit first. The buffer holds it right-justified, and every bit above the selected length reads 0.
- R4: When `cfg_par_off` is 0, one parity bit follows the data. With `cfg_par_even` = 1, data plus parity must hold an even number of ones; with 0, an odd number. A mismatch sets `err_parity`, which stays set until a later character arrives with matching parity. `err_parity` reads 0 whenever `cfg_par_off` is 1.
- R5: A low sample at the first stop bit's centre sets `err_frame`. It stays set until a later character ends with a high stop sample.
- R6: `data_rdy` rises in the same clock cycle as the buffer update. It then stays high until a clock cycle in which `dr_clr_n` is low and no character is being written.
- R7: At each character write, `err_overrun` takes the value `data_rdy` had just before that write.
- R8: The control word {`cfg_len`, `cfg_par_off`, `cfg_par_even`} is captured on every clock with `cfg_load` high. After reset it selects 8 data bits with parity off.
- R9: The search for the next start resumes one tick after the stop-bit sample, about 9 ticks into the first stop bit. A character that begins directly after one stop bit is therefore received.
- R10: While `tick16` stays low, the receiver state does not change and no character is produced, whatever the line does.
- R11: The serial input passes through a two-stage synchroniser. Its reset state is the idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_load | input | 1 | Capture control word while high |
| cfg_len | input | 2 | Data length code (00 = 5 to 11 = 8) |
| cfg_par_off | input | 1 | 1 disables parity |
| cfg_par_even | input | 1 | 1 selects even parity, 0 odd |
| dr_clr_n | input | 1 | Active-low data-ready clear |
| rx_data | output | 8 | Receive buffer, right-justified |
| data_rdy | output | 1 | Character received and not yet acknowledged |
| err_parity | output | 1 | Parity mismatch on the latest character |
| err_frame | output | 1 | Invalid first stop bit on the latest character |
| err_overrun | output | 1 | A character was written while data-ready was still set |

## Verification
The assertions take two things for granted. First, the control word does not change while a character is in flight. Second, `tick16` is a one-cycle pulse, so a frame spans a whole number of ticks per bit. The bench follows both rules: it loads a new format only while the line is idle, and it drives every bit for exactly 16 ticks from a fixed divider. Random frames vary the length, parity mode, deliberate parity and stop-bit faults, and whether the host acknowledges between characters. Directed cases cover glitch starts, a stalled tick, and back-to-back characters.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_TAIL
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_off;
        logic       par_even;
    } rx_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              par_bad;
        logic              stop_bad;
    } rx_char_t;

    localparam rx_cfg_t CFG_RESET = '{len: 2'b11, par_off: 1'b1, par_even: 1'b0};

    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic [BYTE_W-1:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_s,
    input  rx_cfg_t  cfg,
    output logic     xfer,
    output rx_char_t chr
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    rx_state_e          state;
    logic [CW-1:0]      cnt;
    logic [2:0]         idx;
    logic [BYTE_W-1:0]  shreg;
    logic               pbit;
    logic               last_bit;
    logic               mid_start;
    logic               mid_bit;

    assign last_bit  = ({1'b0, idx} == data_bits(cfg.len) - 4'd1);
    assign mid_start = (cnt == CW'(HALF - 1));
    assign mid_bit   = (cnt == CW'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            xfer  <= 1'b0;
            chr   <= '0;
        end else begin
            xfer <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (!rx_s) state <= RX_START;
                    end
                    RX_START: begin
                        if (mid_start) begin
                            cnt <= '0;
                            if (!rx_s) begin
                                state <= RX_DATA;
                                shreg <= '0;
                                idx   <= '0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (mid_bit) begin
                            cnt        <= '0;
                            shreg[idx] <= rx_s;
                            if (last_bit) state <= cfg.par_off ? RX_STOP : RX_PAR;
                            else          idx   <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (mid_bit) begin
                            cnt   <= '0;
                            pbit  <= rx_s;
                            state <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (mid_bit) begin
                            cnt          <= '0;
                            xfer         <= 1'b1;
                            chr.data     <= shreg;
                            chr.stop_bad <= !rx_s;
                            chr.par_bad  <= !cfg.par_off &&
                                            ((^shreg ^ pbit) != !cfg.par_even);
                            state        <= RX_TAIL;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_TAIL: begin
                        state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state) && !xfer);

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        xfer |-> ((chr.data & ~len_mask(cfg.len)) == '0));

    assert_resume_search_R9: assert property (@(posedge clk) disable iff (rst)
        xfer |-> state == RX_TAIL);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        state == RX_START |-> cnt < CW'(HALF));

endmodule

// File: rtl/rx_flags.sv
module rx_flags
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer,
    input  rx_char_t          chr,
    input  logic              dr_clr_n,
    input  logic              par_off,
    output logic [BYTE_W-1:0] rx_data,
    output logic              data_rdy,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);
    logic par_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            data_rdy    <= 1'b0;
            par_flag    <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else if (xfer) begin
            rx_data     <= chr.data;
            data_rdy    <= 1'b1;
            err_overrun <= data_rdy;
            par_flag    <= chr.par_bad;
            err_frame   <= chr.stop_bad;
        end else if (!dr_clr_n) begin
            data_rdy <= 1'b0;
        end
    end

    assign err_parity = par_flag & ~par_off;

    assert_rdy_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(data_rdy) && data_rdy |-> $past(xfer));

    assert_rdy_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !dr_clr_n && !xfer |=> !data_rdy);

    assert_overrun_rule_R7: assert property (@(posedge clk) disable iff (rst)
        xfer |=> err_overrun == $past(data_rdy));

    assert_frame_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(err_frame) && $stable(rx_data));

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic       cfg_load,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_off,
    input  logic       cfg_par_even,
    input  logic       dr_clr_n,
    output logic [7:0] rx_data,
    output logic       data_rdy,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun
);
    rx_cfg_t  cfg_q;
    logic     rx_s;
    logic     xfer;
    rx_char_t chr;

    always_ff @(posedge clk) begin
        if (rst)           cfg_q <= CFG_RESET;
        else if (cfg_load) cfg_q <= '{len: cfg_len, par_off: cfg_par_off, par_even: cfg_par_even};
    end

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (rx_in),
        .d_out (rx_s)
    );

    rx_frame #(.OVS(OVS)) u_frame (
        .clk  (clk),
        .rst  (rst),
        .tick (tick16),
        .rx_s (rx_s),
        .cfg  (cfg_q),
        .xfer (xfer),
        .chr  (chr)
    );

    rx_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .xfer        (xfer),
        .chr         (chr),
        .dr_clr_n    (dr_clr_n),
        .par_off     (cfg_q.par_off),
        .rx_data     (rx_data),
        .data_rdy    (data_rdy),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun)
    );

    assert_sync_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rx_s);

    assert_par_off_low_R4: assert property (@(posedge clk) disable iff (rst)
        xfer && cfg_q.par_off |=> !err_parity);

endmodule

// File: tb/serial_rx_flags_bench.sv
module serial_rx_flags_bench;
    localparam int TDIV = 4;
    localparam int BITC = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_off = 1'b1;
    logic       cfg_par_even = 1'b0;
    logic       dr_clr_n = 1'b1;
    logic [7:0] rx_data;
    logic       data_rdy, err_parity, err_frame, err_overrun;

    logic tick_run = 1'b1;
    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;

    logic [7:0] m_data = '0;
    logic       m_dr = 0, m_pe = 0, m_fe = 0, m_ov = 0;
    logic [1:0] c_len = 2'b11;
    logic       c_off = 1'b1, c_even = 1'b0;

    serial_rx_flags u_serial_rx_flags (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
        .cfg_load(cfg_load), .cfg_len(cfg_len), .cfg_par_off(cfg_par_off),
        .cfg_par_even(cfg_par_even), .dr_clr_n(dr_clr_n),
        .rx_data(rx_data), .data_rdy(data_rdy), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun)
    );

    always #10 clk = ~clk;

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick16 = tick_run && (div == 0);
            div = (div + 1) % TDIV;
        end
    end

    function automatic logic [7:0] fmask(input logic [1:0] len);
        return 8'hFF >> (3 - len);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BITC) @(negedge clk);
    endtask

    task automatic load_cfg(input logic [1:0] len, input logic off, input logic even);
        @(negedge clk);
        cfg_len = len; cfg_par_off = off; cfg_par_even = even; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        c_len = len; c_off = off; c_even = even;
    endtask

    task automatic host_clear();
        @(negedge clk);
        dr_clr_n = 1'b0;
        @(negedge clk);
        dr_clr_n = 1'b1;
        m_dr = 1'b0;
    endtask

    // drives one character in the current format and updates the model
    task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic [7:0] md;
        logic       pb;
        md = d & fmask(c_len);
        rx_in = 1'b0;
        wait_bits(1);
        for (int i = 0; i < 5 + c_len; i++) begin
            rx_in = md[i];
            wait_bits(1);
        end
        if (!c_off) begin
            pb = c_even ? ^md : ~^md;
            rx_in = pb ^ bad_par;
            wait_bits(1);
        end
        rx_in = !bad_stop;
        wait_bits(1);
        rx_in = 1'b1;
        m_ov   = m_dr;
        m_dr   = 1'b1;
        m_data = md;
        m_pe   = !c_off && bad_par;
        m_fe   = bad_stop;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " data R3"}, rx_data, m_data);
        chk({tag, " ready R6"}, data_rdy, m_dr);
        chk({tag, " parity R4"}, err_parity, m_pe && !c_off);
        chk({tag, " frame R5"}, err_frame, m_fe);
        chk({tag, " overrun R7"}, err_overrun, m_ov);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 data", rx_data, 0);
        chk("R1 flags", {data_rdy, err_parity, err_frame, err_overrun}, 0);

        // R8 default format: 8 bits, no parity; R11 synchroniser idles high
        send(8'hA5, 0, 0);
        wait_bits(2);
        check_all("R8 default R11");

        // R2 glitch start: 3 ticks low
        host_clear();
        rx_in = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rx_in = 1'b1;
        wait_bits(2);
        chk("R2 glitch ready", data_rdy, 0);
        chk("R2 glitch data", rx_data, 8'hA5);

        // R10 stalled tick: line activity has no effect
        tick_run = 1'b0;
        rx_in = 1'b0;
        repeat (40 * TDIV) @(negedge clk);
        rx_in = 1'b1;
        repeat (40) @(negedge clk);
        tick_run = 1'b1;
        wait_bits(2);
        chk("R10 stalled ready", data_rdy, 0);

        // R4 parity error persists, then reads 0 when parity disabled
        load_cfg(2'b10, 1'b0, 1'b1);
        send(8'h55, 1, 0);
        wait_bits(2);
        check_all("R4 bad parity");
        send(8'h12, 0, 0);
        wait_bits(2);
        check_all("R4 good parity clears");
        send(8'h7F, 1, 0);
        wait_bits(2);
        load_cfg(2'b10, 1'b1, 1'b1);
        chk("R4 inhibited forces low", err_parity, 0);

        // R5 framing error sticky, then cleared by a good stop
        host_clear();
        load_cfg(2'b00, 1'b0, 1'b0);
        send(8'hFF, 0, 1);
        wait_bits(2);
        check_all("R5 bad stop");
        host_clear();
        send(8'h0A, 0, 0);
        wait_bits(2);
        check_all("R5 good stop clears");

        // R7 overrun without acknowledge, then cleared after acknowledge
        send(8'h13, 0, 0);
        wait_bits(2);
        check_all("R7 overrun set");
        host_clear();
        send(8'h04, 0, 0);
        wait_bits(2);
        check_all("R7 overrun cleared");

        // R9 back-to-back characters with one stop bit
        load_cfg(2'b11, 1'b0, 1'b1);
        host_clear();
        send(8'hC3, 0, 0);
        send(8'h3C, 0, 0);
        wait_bits(2);
        check_all("R9 back to back");

        // random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d;
            logic bp, bs;
            d  = 8'($urandom);
            bp = ($urandom % 4) == 0;
            bs = ($urandom % 5) == 0;
            load_cfg(2'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom % 2) host_clear();
            send(d, bp, bs);
            wait_bits(2);
            check_all("random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule